// File: doc/BRIEF.md
# West-First Adaptive Route Selector

This block computes the route for one input of a two-dimensional mesh switch. Each header carries signed relative offsets toward the destination: a column offset (positive means east) and a row offset (positive means north). From these offsets and a per-link status vector, the block picks exactly one output port. A header that needs any westward travel is sent west with no choice at all. The turn model forbids only turns into west, so every other header may choose adaptively among its productive directions without creating a deadlock cycle.

When east, north or south are productive, the selector prefers links that are neither busy nor faulted. Ties among such links are broken by a rotating pointer, which spreads traffic across them. If no productive link is free, the block still names a productive port so that routing never stalls. It picks a link that is busy but not faulted in preference to a faulted one, and in fixed east, north, south order. A header with both offsets zero is delivered to the local port. Each selection appears one clock after the header is presented.

Top module: `wf_route_top`

## Requirements
- R1: A valid header whose column offset is negative selects west (port code 4), whatever the busy and fault bits say.
- R2: A valid header whose two offsets are both zero selects the local port (port code 0).
- R3: A valid header whose column offset is zero or positive never selects west. The block selects east (code 1) only if the column offset is positive, north (code 2) only if the row offset is positive, and south (code 3) only if the row offset is negative.
- R4: Status bit 0 belongs to east, bit 1 to north, bit 2 to south and bit 3 to west. Among the productive ports, one whose busy bit and fault bit are both clear is chosen whenever such a port exists.
- R5: When several productive ports are free, a pointer over the order east, north, south (reset value east) picks the first free one at or after it. After such a grant, the pointer moves to the port just after the one granted, wrapping from south to east.
- R6: When no productive port is free but some are not faulted, the first port that is not faulted in the order east, north, south is chosen. The pointer does not move.
- R7: When every productive port is faulted, the first productive port in the order east, north, south is still chosen. The pointer does not move.
- R8: The output valid is high in the cycle after a valid header and low in the cycle after an idle one. During idle cycles the port code and the pointer keep their values.
- R9: Reset clears the output valid, sets the port code to local and sets the pointer to east.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdrValid | input | 1 | A header is presented this cycle |
| dx | input | COORD_W | Signed column offset, positive means east |
| dy | input | COORD_W | Signed row offset, positive means north |
| linkBusy | input | 4 | Per-link busy flag (E, N, S, W at bits 0..3) |
| linkFault | input | 4 | Per-link fault flag (E, N, S, W at bits 0..3) |
| selValid | output | 1 | Selected port is valid |
| selPort | output | 3 | Port code: 0 local, 1 east, 2 north, 3 south, 4 west |

## Verification
In a single cycle, the rotating tie-break and the congestion and fault screening can act on the same header. A diagonal header with one candidate free and the other busy or faulted must ignore the pointer and must leave it where it was when nothing was free. The bench creates this overlap with directed sequences, in which ties alternate with partially blocked diagonals and with headers that hit a fully blocked or fully faulted set. It then runs a long random stream with short offsets and dense status bits. A behavioural model keeps its own pointer, predicts every output, and compares its prediction with the outputs each cycle, so one wrong pointer step shows up in the grants that follow.

// File: rtl/wf_route_pkg.sv
package wf_route_pkg;
  localparam int NUM_LINKS = 4;
  localparam int NUM_ADAPT = 3;
  localparam int PTR_W     = $clog2(NUM_ADAPT);

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_EAST  = 3'd1,
    PORT_NORTH = 3'd2,
    PORT_SOUTH = 3'd3,
    PORT_WEST  = 3'd4
  } port_e;

  typedef struct packed {
    logic                 capture;
    logic                 takeWest;
    logic                 takeLocal;
    logic [NUM_ADAPT-1:0] grant;
  } route_strobe_t;
endpackage

// File: rtl/wf_route_dp.sv
module wf_route_dp
  import wf_route_pkg::*;
#(
  parameter int COORD_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic signed [COORD_W-1:0]   dx,
  input  logic signed [COORD_W-1:0]   dy,
  input  logic [NUM_LINKS-1:0]        linkBusy,
  input  logic [NUM_LINKS-1:0]        linkFault,
  input  route_strobe_t               strobe,
  output logic                        westReq,
  output logic                        localReq,
  output logic [NUM_ADAPT-1:0]        candMask,
  output logic [NUM_ADAPT-1:0]        freeMask,
  output logic [NUM_ADAPT-1:0]        safeMask,
  output logic                        selValid,
  output logic [2:0]                  selPort
);
  logic [NUM_ADAPT-1:0] wantDir;
  logic [2:0]           grantCode;

  assign westReq  = (dx < 0);
  assign localReq = (dx == '0) && (dy == '0);

  // bit 0 east, bit 1 north, bit 2 south
  assign wantDir[0] = (dx > 0);
  assign wantDir[1] = (dy > 0);
  assign wantDir[2] = (dy < 0);

  for (genvar i = 0; i < NUM_ADAPT; i++) begin : g_screen
    assign candMask[i] = wantDir[i] & ~westReq;
    assign freeMask[i] = candMask[i] & ~linkBusy[i] & ~linkFault[i];
    assign safeMask[i] = candMask[i] & ~linkFault[i];
  end

  always_comb begin
    grantCode = PORT_LOCAL;
    for (int i = NUM_ADAPT - 1; i >= 0; i--) begin
      if (strobe.grant[i]) grantCode = 3'(i + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      selValid <= 1'b0;
      selPort  <= PORT_LOCAL;
    end else begin
      selValid <= strobe.capture;
      if (strobe.capture) begin
        if (strobe.takeWest)       selPort <= PORT_WEST;
        else if (strobe.takeLocal) selPort <= PORT_LOCAL;
        else                       selPort <= grantCode;
      end
    end
  end
endmodule

// File: rtl/wf_route_ctrl.sv
module wf_route_ctrl
  import wf_route_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hdrValid,
  input  logic                 westReq,
  input  logic                 localReq,
  input  logic [NUM_ADAPT-1:0] candMask,
  input  logic [NUM_ADAPT-1:0] freeMask,
  input  logic [NUM_ADAPT-1:0] safeMask,
  output route_strobe_t        strobe
);
  logic [PTR_W-1:0]     rrPtr;
  logic [PTR_W-1:0]     rrNext;
  logic [NUM_ADAPT-1:0] rrPick;
  logic [NUM_ADAPT-1:0] fbPick;
  logic [NUM_ADAPT-1:0] fbPool;
  logic                 anyFree;
  logic                 adaptGrant;

  assign anyFree = |freeMask;
  assign fbPool  = (|safeMask) ? safeMask : candMask;

  // rotating search over free ports starting at the pointer
  always_comb begin
    rrPick = '0;
    rrNext = rrPtr;
    for (int off = NUM_ADAPT - 1; off >= 0; off--) begin
      int idx;
      idx = int'(rrPtr) + off;
      if (idx >= NUM_ADAPT) idx = idx - NUM_ADAPT;
      if (freeMask[idx]) begin
        rrPick      = '0;
        rrPick[idx] = 1'b1;
        rrNext      = (idx == NUM_ADAPT - 1) ? '0 : PTR_W'(idx + 1);
      end
    end
  end

  // fixed east, north, south order for the blocked case
  always_comb begin
    fbPick = '0;
    for (int i = NUM_ADAPT - 1; i >= 0; i--) begin
      if (fbPool[i]) begin
        fbPick    = '0;
        fbPick[i] = 1'b1;
      end
    end
  end

  assign adaptGrant = hdrValid && !westReq && !localReq && anyFree;

  always_comb begin
    strobe.capture   = hdrValid;
    strobe.takeWest  = westReq;
    strobe.takeLocal = localReq;
    strobe.grant     = anyFree ? rrPick : fbPick;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          rrPtr <= '0;
    else if (adaptGrant) rrPtr <= rrNext;
  end
endmodule

// File: rtl/wf_route_top.sv
module wf_route_top
  import wf_route_pkg::*;
#(
  parameter int COORD_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      hdrValid,
  input  logic signed [COORD_W-1:0] dx,
  input  logic signed [COORD_W-1:0] dy,
  input  logic [3:0]                linkBusy,
  input  logic [3:0]                linkFault,
  output logic                      selValid,
  output logic [2:0]                selPort
);
  route_strobe_t        strobe;
  logic                 westReq;
  logic                 localReq;
  logic [NUM_ADAPT-1:0] candMask;
  logic [NUM_ADAPT-1:0] freeMask;
  logic [NUM_ADAPT-1:0] safeMask;

  wf_route_dp #(.COORD_W(COORD_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .dx(dx), .dy(dy),
    .linkBusy(linkBusy), .linkFault(linkFault), .strobe(strobe),
    .westReq(westReq), .localReq(localReq), .candMask(candMask),
    .freeMask(freeMask), .safeMask(safeMask),
    .selValid(selValid), .selPort(selPort)
  );

  wf_route_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .hdrValid(hdrValid),
    .westReq(westReq), .localReq(localReq), .candMask(candMask),
    .freeMask(freeMask), .safeMask(safeMask), .strobe(strobe)
  );
endmodule

// File: rtl/wf_route_chk.sv
module wf_route_chk #(
  parameter int COORD_W = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      hdrValid,
  input logic signed [COORD_W-1:0] dx,
  input logic signed [COORD_W-1:0] dy,
  input logic [3:0]                linkBusy,
  input logic [3:0]                linkFault,
  input logic                      selValid,
  input logic [2:0]                selPort
);
  logic       adaptive;
  logic [2:0] wantNow;
  logic [2:0] openNow;
  logic [2:0] unfaultedNow;

  assign adaptive     = hdrValid && !(dx < 0) && !(dx == '0 && dy == '0);
  assign wantNow      = {dy < 0, dy > 0, dx > 0};
  assign openNow      = wantNow & ~linkBusy[2:0] & ~linkFault[2:0];
  assign unfaultedNow = wantNow & ~linkFault[2:0];

  p_west_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hdrValid && (dx < 0) |=> selValid && selPort == 3'd4);

  p_local_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hdrValid && dx == '0 && dy == '0 |=> selPort == 3'd0);

  p_no_west_turn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hdrValid && !(dx < 0) |=> selPort != 3'd4);

  p_productive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adaptive |=> (selPort == 3'd1 && $past(dx) > 0) ||
                 (selPort == 3'd2 && $past(dy) > 0) ||
                 (selPort == 3'd3 && $past(dy) < 0));

  p_prefer_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adaptive && (|openNow) |=> (selPort == 3'd1 && $past(openNow[0])) ||
                               (selPort == 3'd2 && $past(openNow[1])) ||
                               (selPort == 3'd3 && $past(openNow[2])));

  p_avoid_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adaptive && (|unfaultedNow) |=> (selPort == 3'd1 && $past(unfaultedNow[0])) ||
                                    (selPort == 3'd2 && $past(unfaultedNow[1])) ||
                                    (selPort == 3'd3 && $past(unfaultedNow[2])));

  p_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hdrValid |=> selValid);

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hdrValid |=> !selValid && $stable(selPort));
endmodule

bind wf_route_top wf_route_chk #(.COORD_W(COORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hdrValid(hdrValid), .dx(dx), .dy(dy),
  .linkBusy(linkBusy), .linkFault(linkFault),
  .selValid(selValid), .selPort(selPort)
);

// File: tb/sim_wf_route_top.sv
module sim_wf_route_top;
  localparam int CW = 4;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 hdrValid = 1'b0;
  logic signed [CW-1:0] dx = '0;
  logic signed [CW-1:0] dy = '0;
  logic [3:0]           linkBusy = '0;
  logic [3:0]           linkFault = '0;
  logic                 selValid;
  logic [2:0]           selPort;

  int    vectors = 0;
  int    fails = 0;
  bit    finished = 0;
  int    mPtr = 0;
  int    expValid = 0;
  int    expPort = 0;
  string expTag = "R9";

  always #5 clk = ~clk;

  wf_route_top #(.COORD_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .hdrValid(hdrValid), .dx(dx), .dy(dy),
    .linkBusy(linkBusy), .linkFault(linkFault),
    .selValid(selValid), .selPort(selPort)
  );

  task automatic compareNow();
    vectors++;
    if (int'(selValid) != expValid || int'(selPort) != expPort) begin
      fails++;
      $display("FAIL %s: selValid=%0d selPort=%0d expected selValid=%0d selPort=%0d",
               expTag, selValid, selPort, expValid, expPort);
    end
  endtask

  // behavioural prediction of the next output
  task automatic predict(input int v, input int x, input int y, input int b, input int f);
    int want[3];
    int free[3];
    int safe[3];
    int nFree;
    int nSafe;
    if (v == 0) begin
      expValid = 0; expTag = "R8"; return;
    end
    expValid = 1;
    if (x < 0) begin
      expPort = 4; expTag = "R1"; return;
    end
    if (x == 0 && y == 0) begin
      expPort = 0; expTag = "R2"; return;
    end
    want[0] = (x > 0); want[1] = (y > 0); want[2] = (y < 0);
    nFree = 0; nSafe = 0;
    for (int i = 0; i < 3; i++) begin
      free[i] = want[i] && !b[i] && !f[i];
      safe[i] = want[i] && !f[i];
      nFree += free[i];
      nSafe += safe[i];
    end
    if (nFree > 0) begin
      for (int off = 0; off < 3; off++) begin
        int k;
        k = (mPtr + off) % 3;
        if (free[k] != 0) begin
          expPort = k + 1;
          mPtr = (k + 1) % 3;
          break;
        end
      end
      expTag = (nFree > 1) ? "R3 R5" : "R3 R4";
    end else begin
      for (int i = 0; i < 3; i++) begin
        if ((nSafe > 0) ? (safe[i] != 0) : (want[i] != 0)) begin
          expPort = i + 1;
          break;
        end
      end
      expTag = (nSafe > 0) ? "R3 R6" : "R3 R7";
    end
  endtask

  task automatic step(input int v, input int x, input int y, input int b, input int f);
    @(negedge clk);
    compareNow();
    hdrValid  = v[0];
    dx        = CW'(x);
    dy        = CW'(y);
    linkBusy  = b[3:0];
    linkFault = f[3:0];
    predict(v, x, y, b, f);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compareNow();              // R9: reset state
    rst_n = 1'b1;
    expTag = "R9";
    // R5: pointer starts at east, rotates on ties
    step(1, 2, 3, 0, 0);
    step(1, 2, 3, 0, 0);
    step(1, 2, 3, 0, 0);
    step(1, 1, -2, 0, 0);
    // R1: west despite everything blocked
    step(1, -1, 0, 15, 15);
    step(1, -3, 5, 15, 0);
    // R2: local
    step(1, 0, 0, 15, 15);
    // R4: one free, other busy / faulted; pointer overlap
    step(1, 3, 1, 1, 0);
    step(1, 3, -1, 0, 4);
    // R6: nothing free, east busy, north faulted -> east
    step(1, 2, 2, 1, 2);
    // R6: east faulted, north busy -> north
    step(1, 2, 2, 2, 1);
    // R7: all faulted -> east, pointer untouched
    step(1, 2, -2, 0, 5);
    step(1, 0, -4, 4, 4);
    // R8: idle cycles keep port
    step(0, -2, 0, 0, 0);
    step(0, 1, 1, 0, 0);
    step(1, 1, 1, 0, 0);
    // random stream
    for (int n = 0; n < 4000; n++) begin
      step(($urandom_range(0, 7) != 0), int'($urandom_range(0, 6)) - 3,
           int'($urandom_range(0, 6)) - 3, int'($urandom_range(0, 15)),
           ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 15)) : 0);
    end
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule